// File: doc/BRIEF.md
# Read-during-write bypass for an old-data memory read port

This block sits behind the registered read port of a synchronous memory whose read returns the contents from before a same-cycle write. It makes that port show the newly written value instead. On every read-enabled clock edge it captures the write data and one bypass flag per write-enable lane and per read slice. After the edge it substitutes the captured write data for the raw memory output, but only in the lanes whose flag is set.

The read port may be 2^`WIDE_LOG2` words wide while the write port is one word wide. Each word slice of the read data has its own sub-address, formed from the upper read address bits and the slice index. The write address is compared against each slice separately. The flags obey the same sync reset, async reset and hold rules as the memory's own read register, so resetting or stalling the port gives consistent data.

Top module: `rdw_bypass`

## Requirements
- R1: With no write lane enabled toward the word being read, `rdata_o` equals `mem_rdata_i`, slice for slice.
- R2: When a read and a write in the same enabled cycle target the same word, after that clock edge each lane whose write-enable bit was 1 shows the written lane value. The other lanes show the old memory data. Lane l covers data bits [l*LANE_W +: LANE_W].
- R3: A write to a word that no read slice covers produces no bypass in any lane.
- R4: For a wide read, slice s (bits [s*DATA_W +: DATA_W], slice 0 lowest) has word address {raddr_i[ADDR_W-1:WIDE_LOG2], s}. Only the slice whose address equals `waddr_i` is bypassed. In each lane, at most one slice's flag is set.
- R5: While `ren_i` is 0 and no sync reset acts, the captured write data and the flags hold. A write during such a cycle does not change `rdata_o` beyond the raw memory data.
- R6: `srst_i` together with `ren_i` clears every flag at the clock edge.
- R7: With the default priority (sync reset over clock enable), `srst_i` clears the flags even when `ren_i` is 0.
- R8: `arst_i` clears every flag at once, with no clock edge needed.
- R9: After reset, no lane is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock, rising edge |
| arst_i | input | 1 | Asynchronous reset of the read port, active high |
| srst_i | input | 1 | Synchronous reset of the read port, active high |
| ren_i | input | 1 | Read enable (clock enable of the read port) |
| raddr_i | input | ADDR_W | Read word address |
| mem_rdata_i | input | DATA_W<<WIDE_LOG2 | Registered old-data output of the memory |
| waddr_i | input | ADDR_W | Write word address |
| wen_i | input | LANES | Per-lane write enables |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W<<WIDE_LOG2 | Corrected read data |

## Verification
Reads are tried against writes to the same word with both lanes enabled and with a single lane enabled. This separates per-lane substitution from whole-word substitution. Writes aimed at the upper and at the lower slice of a two-word read show whether the sub-address comparison picks the correct slice. A write to an unrelated word shows whether the address compare gates the flags. Stalled cycles with a colliding write, sync resets with the enable high and low, and a mid-cycle async reset each follow a cycle with a live bypass. This distinguishes cleared flags from held flags.

// File: rtl/rdw_bypass_pkg.sv
package rdw_bypass_pkg;
    // Which control wins when sync reset and clock enable disagree.
    typedef enum logic {
        SRST_OVER_CE = 1'b0,  // sync reset acts regardless of the enable
        CE_OVER_SRST = 1'b1   // sync reset acts only on enabled cycles
    } srst_prio_e;
endpackage

// File: rtl/rdw_hit_gen.sv
module rdw_hit_gen #(
    parameter int ADDR_W    = 4,
    parameter int LANES     = 2,
    parameter int WIDE_LOG2 = 1,
    localparam int SLICES   = 1 << WIDE_LOG2,
    localparam int NCOND    = SLICES * LANES
) (
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [LANES-1:0]  wen_i,
    output logic [NCOND-1:0]  hit_o
);
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        logic [ADDR_W-1:0] word_addr;
        if (WIDE_LOG2 == 0) begin : g_narrow
            assign word_addr = raddr_i;
        end else begin : g_wide
            assign word_addr = {raddr_i[ADDR_W-1:WIDE_LOG2], WIDE_LOG2'(s)};
        end
        logic addr_eq;
        assign addr_eq = (word_addr == waddr_i);
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign hit_o[s*LANES + l] = wen_i[l] & addr_eq;
        end
    end
endmodule

// File: rtl/rdw_bypass_state.sv
module rdw_bypass_state
    import rdw_bypass_pkg::*;
#(
    parameter int         DATA_W    = 16,
    parameter int         LANES     = 2,
    parameter int         SLICES    = 2,
    parameter srst_prio_e SRST_PRIO = SRST_OVER_CE,
    localparam int        NCOND     = SLICES * LANES
) (
    input  logic              clk_i,
    input  logic              arst_i,
    input  logic              srst_i,
    input  logic              ren_i,
    input  logic [NCOND-1:0]  hit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NCOND-1:0]  cond_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] wd;
        logic [NCOND-1:0]  cond;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ren_i) st_d.wd = wdata_i;
        if (SRST_PRIO == CE_OVER_SRST) begin
            if (ren_i) st_d.cond = srst_i ? '0 : hit_i;
        end else begin
            if (srst_i)     st_d.cond = '0;
            else if (ren_i) st_d.cond = hit_i;
        end
    end

    // Only the flags take the async reset; the data register has none.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) st_q.cond <= '0;
        else        st_q      <= st_d;
    end

    assign cond_o  = st_q.cond;
    assign wdata_o = st_q.wd;

    // R6 and R7: an effective sync reset leaves no flag set
    assert_srst_clears_R6: assert property (@(posedge clk_i) disable iff (arst_i)
        srst_i && (ren_i || SRST_PRIO == SRST_OVER_CE) |=> cond_o == '0);

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (arst_i)
        !ren_i && !(srst_i && SRST_PRIO == SRST_OVER_CE) |=> $stable(cond_o) && $stable(wdata_o));

    assert_wdata_capture_R2: assert property (@(posedge clk_i) disable iff (arst_i)
        ren_i |=> wdata_o == $past(wdata_i));

    assert_cond_capture_R3: assert property (@(posedge clk_i) disable iff (arst_i)
        ren_i && !srst_i |=> cond_o == $past(hit_i));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        logic [SLICES-1:0] col;
        for (genvar s = 0; s < SLICES; s++) begin : g_col
            assign col[s] = st_q.cond[s*LANES + l];
        end
        assert_lane_single_slice_R4: assert property (@(posedge clk_i) disable iff (arst_i)
            $onehot0(col));
    end
endmodule

// File: rtl/rdw_out_mux.sv
module rdw_out_mux #(
    parameter int  DATA_W = 16,
    parameter int  LANES  = 2,
    parameter int  SLICES = 2,
    localparam int LANE_W = DATA_W / LANES,
    localparam int NCOND  = SLICES * LANES,
    localparam int RDW    = DATA_W * SLICES
) (
    input  logic [RDW-1:0]    mem_rdata_i,
    input  logic [DATA_W-1:0] wdata_q_i,
    input  logic [NCOND-1:0]  cond_q_i,
    output logic [RDW-1:0]    rdata_o
);
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int BASE = s*DATA_W + l*LANE_W;
            assign rdata_o[BASE +: LANE_W] = cond_q_i[s*LANES + l]
                                           ? wdata_q_i[l*LANE_W +: LANE_W]
                                           : mem_rdata_i[BASE +: LANE_W];
        end
    end
endmodule

// File: rtl/rdw_bypass.sv
module rdw_bypass
    import rdw_bypass_pkg::*;
#(
    parameter int         ADDR_W    = 4,
    parameter int         DATA_W    = 16,
    parameter int         LANES     = 2,
    parameter int         WIDE_LOG2 = 1,
    parameter srst_prio_e SRST_PRIO = SRST_OVER_CE,
    localparam int        SLICES    = 1 << WIDE_LOG2,
    localparam int        NCOND     = SLICES * LANES,
    localparam int        RDW       = DATA_W * SLICES
) (
    input  logic              clk_i,
    input  logic              arst_i,
    input  logic              srst_i,
    input  logic              ren_i,
    input  logic [ADDR_W-1:0] raddr_i,
    input  logic [RDW-1:0]    mem_rdata_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [LANES-1:0]  wen_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [RDW-1:0]    rdata_o
);
    logic [NCOND-1:0]  hit;
    logic [NCOND-1:0]  cond_q;
    logic [DATA_W-1:0] wd_q;

    rdw_hit_gen #(
        .ADDR_W(ADDR_W), .LANES(LANES), .WIDE_LOG2(WIDE_LOG2)
    ) u_hit (
        .raddr_i(raddr_i), .waddr_i(waddr_i), .wen_i(wen_i), .hit_o(hit)
    );

    rdw_bypass_state #(
        .DATA_W(DATA_W), .LANES(LANES), .SLICES(SLICES), .SRST_PRIO(SRST_PRIO)
    ) u_state (
        .clk_i(clk_i), .arst_i(arst_i), .srst_i(srst_i), .ren_i(ren_i),
        .hit_i(hit), .wdata_i(wdata_i), .cond_o(cond_q), .wdata_o(wd_q)
    );

    rdw_out_mux #(
        .DATA_W(DATA_W), .LANES(LANES), .SLICES(SLICES)
    ) u_mux (
        .mem_rdata_i(mem_rdata_i), .wdata_q_i(wd_q), .cond_q_i(cond_q), .rdata_o(rdata_o)
    );
endmodule

// File: tb/sim_rdw_bypass.sv
module sim_rdw_bypass;
    localparam int AW = 4, DW = 16, LANES = 2, LW = 8, RDW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic arst = 1'b0, srst = 1'b0, ren = 1'b0;
    logic [AW-1:0] raddr = '0, waddr = '0;
    logic [LANES-1:0] wen = '0;
    logic [DW-1:0] wdata = '0;
    logic [RDW-1:0] mrd, rdata, exp_v;
    logic [DW-1:0] mem [16];

    int n_chk = 0, n_bad = 0;

    rdw_bypass #(.ADDR_W(AW), .DATA_W(DW), .LANES(LANES), .WIDE_LOG2(1)) u0 (
        .clk_i(clk), .arst_i(arst), .srst_i(srst), .ren_i(ren), .raddr_i(raddr),
        .mem_rdata_i(mrd), .waddr_i(waddr), .wen_i(wen), .wdata_i(wdata), .rdata_o(rdata)
    );

    // Old-data memory model with a resettable read register.
    always @(posedge clk or posedge arst) begin
        if (arst)      mrd <= '0;
        else if (srst) mrd <= '0;
        else if (ren)  mrd <= {mem[{raddr[3:1], 1'b1}], mem[{raddr[3:1], 1'b0}]};
    end
    always @(posedge clk) begin
        for (int l = 0; l < LANES; l++)
            if (wen[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
    end

    function automatic logic [RDW-1:0] model_out(logic [AW-1:0] ra, logic [LANES-1:0] we,
                                                 logic [AW-1:0] wa, logic [DW-1:0] wd);
        logic [RDW-1:0] v;
        for (int s = 0; s < 2; s++) begin
            logic [AW-1:0] word = {ra[3:1], s[0]};
            for (int l = 0; l < LANES; l++)
                v[s*DW + l*LW +: LW] = (we[l] && wa == word) ? wd[l*LW +: LW]
                                                             : mem[word][l*LW +: LW];
        end
        return v;
    endfunction

    task automatic chk(string req, logic [RDW-1:0] e);
        n_chk++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected=%h", req, rdata, e);
        end
    endtask

    task automatic drive(logic r, logic s, logic [AW-1:0] ra, logic [LANES-1:0] we,
                         logic [AW-1:0] wa, logic [DW-1:0] wd);
        @(negedge clk);
        ren = r; srst = s; raddr = ra; wen = we; waddr = wa; wdata = wd;
    endtask

    // {ren, raddr, wen, waddr, wdata}
    localparam logic [26:0] VEC [7] = '{
        {1'b1, 4'd2, 2'b00, 4'd0, 16'h0000},  // R1 plain read
        {1'b1, 4'd4, 2'b11, 4'd4, 16'h1234},  // R2 both lanes, slice 0
        {1'b1, 4'd4, 2'b01, 4'd5, 16'h5678},  // R4 upper slice, low lane only
        {1'b1, 4'd6, 2'b10, 4'd6, 16'h9ABC},  // R2 high lane only
        {1'b1, 4'd8, 2'b11, 4'd3, 16'h1111},  // R3 unrelated word
        {1'b1, 4'd2, 2'b00, 4'd0, 16'h0000},  // R1 read back written word
        {1'b1, 4'd0, 2'b11, 4'd1, 16'hBEEF}   // R4 upper slice, both lanes
    };

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i * 16'h0111);
        #1 arst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        arst = 1'b0;
        chk("R9", '0);

        for (int i = 0; i < 7; i++) begin
            logic [26:0] v = VEC[i];
            drive(v[26], 1'b0, v[25:22], v[21:20], v[19:16], v[15:0]);
            exp_v = model_out(v[25:22], v[21:20], v[19:16], v[15:0]);
            @(posedge clk); #5;
            chk("R2/R3/R4 vector", exp_v);
        end

        // R5: stalled read, colliding write leaves the output alone
        exp_v = rdata;
        drive(1'b0, 1'b0, 4'd0, 2'b11, 4'd0, 16'h7777);
        @(posedge clk); #5;
        chk("R5", exp_v);

        // R6: sync reset with enable clears the bypass
        drive(1'b1, 1'b1, 4'd0, 2'b11, 4'd0, 16'h2222);
        @(posedge clk); #5;
        chk("R6", '0);

        // R2: re-arm a bypass in slice 0
        drive(1'b1, 1'b0, 4'd0, 2'b11, 4'd0, 16'h3333);
        exp_v = model_out(4'd0, 2'b11, 4'd0, 16'h3333);
        @(posedge clk); #5;
        chk("R2", exp_v);

        // R7: sync reset without enable still clears
        drive(1'b0, 1'b1, 4'd0, 2'b00, 4'd0, 16'h0000);
        @(posedge clk); #5;
        chk("R7", '0);

        // R4: bypass in slice 1
        drive(1'b1, 1'b0, 4'd0, 2'b11, 4'd1, 16'h4444);
        exp_v = model_out(4'd0, 2'b11, 4'd1, 16'h4444);
        @(posedge clk); #5;
        chk("R4", exp_v);

        // R8: async reset mid-cycle
        drive(1'b0, 1'b0, 4'd0, 2'b00, 4'd0, 16'h0000);
        #3 arst = 1'b1;
        #1 chk("R8", '0);
        @(negedge clk);
        arst = 1'b0;

        // R1: plain read after reset
        drive(1'b1, 1'b0, 4'd0, 2'b00, 4'd0, 16'h0000);
        exp_v = model_out(4'd0, 2'b00, 4'd0, 16'h0000);
        @(posedge clk); #5;
        chk("R1", exp_v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 10000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run still active (expected finished)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule